// File: doc/BRIEF.md
# Double-Rate PCM Slave Port

This block is the serial side of a voice channel that runs in the double-clock 2B+D timing mode. One data clock drives the block. That clock runs at twice the PCM bit rate, so each serial bit lasts two clock cycles. Every 8 kHz frame, one parallel PCM word goes out serially and one serial word comes in and is presented in parallel.

A frame-sync pulse marks the start of each frame. A channel-select input chooses whether both directions use the first or the second time slot. The second slot starts sixteen clocks after the first. A mode detector watches the level of a reference-clock pin at each frame start. The port moves data only after that pin has been low for two frame starts in a row. A missing-sync watchdog keeps the port silent when frame sync stops.

Top module: `gci_pcm_port`

## Requirements
- R1: A frame starts at the first rising clock edge at which `fsync` is sampled high after it was sampled low. The clock cycle after that edge is frame phase 0, and each later edge advances the phase by one.
- R2: `chan_sel` is sampled at the frame-start edge and holds for the whole frame. With 0, the slot covers phases 0 to 15. With 1, the slot covers phases 16 to 31. A change of `chan_sel` or `tx_word` after the frame-start edge has no effect on that frame.
- R3: `tx_word` is sampled at the frame-start edge and sent MSB first. Bit `tx_word[7-k]` is on `tx_dout` during slot phases 2k and 2k+1, counted from the slot start.
- R4: `tx_oe` is high for the first 15 phases of the selected slot and low at all other times. `tx_dout` is 0 whenever `tx_oe` is low.
- R5: `rx_din` is sampled at the rising edge that ends slot phase 2k, for k from 0 to 7. The first sample is the MSB, `rx_word[7]`.
- R6: `rx_valid` is high for exactly one cycle, at slot phase 15, and `rx_word` then holds the received word. `rx_word` changes at no other time.
- R7: `gci_mode` goes high at the second consecutive frame start with `ref_lvl` low. A frame start with `ref_lvl` high clears `gci_mode` and the count of low starts.
- R8: While `gci_mode` is low, `tx_oe` stays low and `rx_valid` never rises. The mode that applies to a frame is the one set at that frame's own start edge.
- R9: If no frame start occurs for FRAME_CLKS+MARGIN clocks, the port stops driving and receiving until the next frame start. Frame starts must be at least 32 clocks apart.
- R10: After reset, `tx_oe`, `tx_dout`, `rx_valid`, `gci_mode` and `rx_word` are all 0, and the watchdog counts as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, twice the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync input |
| chan_sel | input | 1 | Slot select: 0 = first slot, 1 = second slot |
| ref_lvl | input | 1 | Level of the reference-clock pin, used for mode detection |
| tx_word | input | 8 | Parallel word to transmit |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output-enable for `tx_dout` |
| rx_din | input | 1 | Serial receive data |
| rx_word | output | 8 | Last word received |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| gci_mode | output | 1 | High while double-rate mode is selected |

## Verification
The properties assume that `fsync` and `ref_lvl` are stable around each rising clock edge. They also assume that consecutive frame starts are far enough apart for one slot to finish before the next frame begins. The bench changes every input at the falling edge. It spaces frame starts 65 clocks apart, well above the 32-clock minimum and below the watchdog limit. It holds `fsync` low for only one long stretch, which is used to exercise the watchdog.

// File: rtl/gci_pcm_pkg.sv
package gci_pcm_pkg;
    typedef enum logic {
        CH_FIRST  = 1'b0,
        CH_SECOND = 1'b1
    } chan_e;
endpackage

// File: rtl/gci_mode_det.sv
module gci_mode_det #(
    parameter int unsigned ARM_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_rise,
    input  logic ref_lvl,
    output logic gci_d_o,
    output logic gci_q_o
);
    localparam int unsigned CW = $clog2(ARM_EDGES + 1);

    typedef struct packed {
        logic [CW-1:0] lows;
        logic          gci;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_rise) begin
            if (ref_lvl) begin
                st_d.lows = '0;
                st_d.gci  = 1'b0;
            end else begin
                if (st_q.lows != CW'(ARM_EDGES))
                    st_d.lows = st_q.lows + 1'b1;
                st_d.gci = (st_d.lows == CW'(ARM_EDGES));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gci_d_o = st_d.gci;
    assign gci_q_o = st_q.gci;
endmodule

// File: rtl/gci_frame_timer.sv
module gci_frame_timer
    import gci_pcm_pkg::*;
#(
    parameter int unsigned LIMIT = 72,
    parameter int unsigned CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          chan_sel,
    output logic          rise_o,
    output logic [CW-1:0] cnt_d_o,
    output logic [CW-1:0] cnt_q_o,
    output logic          chan_d_o,
    output logic          chan_q_o,
    output logic          ok_d_o,
    output logic          ok_q_o
);
    typedef struct packed {
        logic          fs;
        logic [CW-1:0] cnt;
        chan_e         chan;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d    = st_q;
        rise    = fsync & ~st_q.fs;
        st_d.fs = fsync;
        if (rise) begin
            st_d.cnt  = '0;
            st_d.chan = chan_e'(chan_sel);
        end else if (st_q.cnt != CW'(LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fs   <= 1'b0;
            st_q.cnt  <= CW'(LIMIT);
            st_q.chan <= CH_FIRST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o   = rise;
    assign cnt_d_o  = st_d.cnt;
    assign cnt_q_o  = st_q.cnt;
    assign chan_d_o = (st_d.chan == CH_SECOND);
    assign chan_q_o = (st_q.chan == CH_SECOND);
    assign ok_d_o   = (st_d.cnt != CW'(LIMIT));
    assign ok_q_o   = (st_q.cnt != CW'(LIMIT));
endmodule

// File: rtl/gci_tx_ser.sv
module gci_tx_ser #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned CW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [CW-1:0]     cnt_d,
    input  logic              chan_d,
    input  logic              en_d,
    input  logic [WORD_W-1:0] tx_word,
    output logic              dout,
    output logic              oe
);
    localparam int unsigned SLOT = 2 * WORD_W;
    localparam int unsigned IW   = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              dout;
        logic              oe;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] base;
    logic [CW-1:0] rel;
    logic          in_slot;
    logic [IW-1:0] bit_idx;

    always_comb begin
        st_d      = st_q;
        st_d.hold = rise ? tx_word : st_q.hold;
        base      = chan_d ? CW'(SLOT) : '0;
        rel       = cnt_d - base;
        in_slot   = (cnt_d >= base) && (cnt_d < base + CW'(SLOT));
        bit_idx   = IW'(WORD_W - 1) - IW'(rel >> 1);
        st_d.oe   = en_d && in_slot && (rel < CW'(SLOT - 1));
        st_d.dout = st_d.oe ? st_d.hold[bit_idx] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign oe   = st_q.oe;
endmodule

// File: rtl/gci_rx_deser.sv
module gci_rx_deser #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned CW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cnt_q,
    input  logic              chan_q,
    input  logic              en_q,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int unsigned SLOT = 2 * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic              valid;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] base;
    logic [CW-1:0] rel;
    logic          in_slot;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        base       = chan_q ? CW'(SLOT) : '0;
        rel        = cnt_q - base;
        in_slot    = (cnt_q >= base) && (cnt_q < base + CW'(SLOT));
        if (en_q && in_slot && !rel[0]) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], rx_din};
            if (rel == CW'(SLOT - 2)) begin
                st_d.word  = st_d.sh;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.word;
    assign rx_valid = st_q.valid;
endmodule

// File: rtl/gci_pcm_port.sv
module gci_pcm_port #(
    parameter int unsigned WORD_W     = 8,
    parameter int unsigned FRAME_CLKS = 64,
    parameter int unsigned MARGIN     = 8,
    parameter int unsigned ARM_EDGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              chan_sel,
    input  logic              ref_lvl,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_dout,
    output logic              tx_oe,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              gci_mode
);
    localparam int unsigned LIMIT = FRAME_CLKS + MARGIN;
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    logic          rise;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          chan_d, chan_q;
    logic          ok_d, ok_q;
    logic          gci_d, gci_q;

    gci_frame_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .chan_sel (chan_sel),
        .rise_o   (rise),
        .cnt_d_o  (cnt_d),
        .cnt_q_o  (cnt_q),
        .chan_d_o (chan_d),
        .chan_q_o (chan_q),
        .ok_d_o   (ok_d),
        .ok_q_o   (ok_q)
    );

    gci_mode_det #(.ARM_EDGES(ARM_EDGES)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_rise (rise),
        .ref_lvl    (ref_lvl),
        .gci_d_o    (gci_d),
        .gci_q_o    (gci_q)
    );

    gci_tx_ser #(.WORD_W(WORD_W), .CW(CW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .cnt_d   (cnt_d),
        .chan_d  (chan_d),
        .en_d    (ok_d & gci_d),
        .tx_word (tx_word),
        .dout    (tx_dout),
        .oe      (tx_oe)
    );

    gci_rx_deser #(.WORD_W(WORD_W), .CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .chan_q   (chan_q),
        .en_q     (ok_q & gci_q),
        .rx_din   (rx_din),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assign gci_mode = gci_q;
endmodule

// File: rtl/gci_pcm_port_chk.sv
module gci_pcm_port_chk #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic              ref_lvl,
    input logic              tx_dout,
    input logic              tx_oe,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic              gci_mode
);
    localparam int unsigned MAXRUN = 2 * WORD_W - 1;
    localparam int unsigned RW     = $clog2(MAXRUN + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         run_q <= '0;
        else if (!tx_oe)                    run_q <= '0;
        else if (run_q != RW'(MAXRUN + 1))  run_q <= run_q + 1'b1;
    end

    AST_OE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> gci_mode); // R8
    AST_OE_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (run_q < RW'(MAXRUN))); // R4
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_dout); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid); // R6
    AST_MODE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gci_mode) |-> $past(fsync && !ref_lvl)); // R7
    AST_MODE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gci_mode) |-> $past(fsync && ref_lvl)); // R7
endmodule

bind gci_pcm_port gci_pcm_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .ref_lvl  (ref_lvl),
    .tx_dout  (tx_dout),
    .tx_oe    (tx_oe),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .gci_mode (gci_mode)
);

// File: tb/tb_gci_pcm_port.sv
module tb_gci_pcm_port;
    localparam int FR = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       chan_sel = 1'b0;
    logic       ref_lvl = 1'b1;
    logic [7:0] tx_word = 8'h00;
    logic       rx_din = 1'b0;
    logic       tx_dout, tx_oe, rx_valid, gci_mode;
    logic [7:0] rx_word;

    int checks = 0;
    int errors = 0;
    int lowc   = 0;
    bit gexp   = 1'b0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gci_pcm_port dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .chan_sel(chan_sel),
        .ref_lvl(ref_lvl), .tx_word(tx_word), .tx_dout(tx_dout),
        .tx_oe(tx_oe), .rx_din(rx_din), .rx_word(rx_word),
        .rx_valid(rx_valid), .gci_mode(gci_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One frame of FR+1 clocks; expected values are computed from R1..R8
    task automatic run_frame(input bit ch, input bit rl, input logic [7:0] txw,
                             input logic [7:0] rxw);
        for (int p = -1; p < FR; p++) begin
            @(negedge clk);
            if (p == 0) begin
                chk(gci_mode == gexp, "R7 mode", int'(gci_mode), int'(gexp));
                fsync    = 1'b0;
                chan_sel = ~ch;       // R2: late change ignored
                tx_word  = ~txw;      // R2: late change ignored
            end
            if (p >= 0) begin
                int  base = ch ? 16 : 0;
                int  rel  = p - base;
                bit  ins  = (p >= base) && (p < base + 16);
                bit  oe_e = gexp && ins && (rel < 15);
                bit  do_e = oe_e ? txw[7 - rel / 2] : 1'b0;
                bit  v_e  = gexp && ins && (rel == 15);
                chk(tx_oe == oe_e, "R4/R8 tx_oe", int'(tx_oe), int'(oe_e));
                chk(tx_dout == do_e, "R3 tx_dout", int'(tx_dout), int'(do_e));
                chk(rx_valid == v_e, "R6/R8 rx_valid", int'(rx_valid), int'(v_e));
                if (v_e) chk(rx_word == rxw, "R5 rx_word", int'(rx_word), int'(rxw));
                // drive the bit sampled at the edge ending phase p
                if (ins && (rel % 2 == 0)) rx_din = rxw[7 - rel / 2];
                else                       rx_din = ~rx_din;
            end else begin
                fsync    = 1'b1;
                chan_sel = ch;
                ref_lvl  = rl;
                tx_word  = txw;
                if (rl) lowc = 0;
                else if (lowc < 2) lowc++;
                gexp = (lowc >= 2);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(tx_oe == 0 && tx_dout == 0 && rx_valid == 0, "R10 outputs", int'(tx_oe), 0);
        chk(gci_mode == 0, "R10 mode", int'(gci_mode), 0);
        chk(rx_word == 0, "R10 rx_word", int'(rx_word), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7/R8: reference high, then one low, then two lows
        run_frame(1'b0, 1'b1, 8'hA5, 8'h3C);
        run_frame(1'b1, 1'b0, 8'hC3, 8'h81);
        run_frame(1'b0, 1'b0, 8'h96, 8'h7E);
        run_frame(1'b1, 1'b1, 8'h0F, 8'hF0);   // drops mode
        run_frame(1'b0, 1'b0, 8'h55, 8'hAA);   // count 1 again
        run_frame(1'b1, 1'b0, 8'h12, 8'h34);   // armed

        // R1-R6: exhaustive word sweep in both slots
        for (int w = 0; w < 256; w++) begin
            run_frame(1'b0, 1'b0, 8'(w), 8'(w) ^ 8'h5A);
            run_frame(1'b1, 1'b0, 8'(w) ^ 8'hFF, 8'(w));
        end

        // R9: frame sync stops; port must stay quiet
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            chk(tx_oe == 0, "R9 tx_oe", int'(tx_oe), 0);
            chk(rx_valid == 0, "R9 rx_valid", int'(rx_valid), 0);
        end
        run_frame(1'b1, 1'b0, 8'hE7, 8'h18);
        run_frame(1'b0, 1'b0, 8'h81, 8'hFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule